// File: doc/BRIEF.md
# Black-Level Clamp Feedback Controller

This block closes a digital control loop around an image-sensor front end. On every sensor line it measures the black level during a short window that follows the optical-black pulse. It compares that level with a programmable target and integrates the scaled difference into a signed correction word. An external current DAC turns the correction word into an offset.

The loop has two speeds. A strobe from the gain logic switches the loop into a fast acquisition mode, in which each correction step is multiplied by a selectable factor. The loop leaves fast mode only after the error has stayed within 64 LSB for a selectable number of evaluations. An option smooths the measurement over four lines before the error is formed.

Top module: `black_clamp_loop`

## Requirements
- R1: The active pulse edge is the first clock in which the active OB level is seen after an inactive one; that clock is cycle 0. The measured line level is floor(sum/8) of the samples in cycles 5 to 12. Samples in any other cycle do not affect it.
- R2: A window counts only if the active level is present in cycles 0, 1 and 2; a shorter pulse gives no update. With `ob_inv`=0 the active level is high, and with `ob_inv`=1 it is low.
- R3: The target is 2*`clamp_code`+14 LSB, and error = target minus measured level. In normal mode the correction grows by exactly the error at each evaluation.
- R4: A one-clock `gain_chg` pulse enters fast mode. In fast mode each step is error*(4 << `fast_sel`), so `fast_sel` values 0, 1, 2 and 3 give factors 4, 8, 16 and 32.
- R5: In fast mode, an evaluation with |error| > 64 keeps fast mode and restarts the count of quiet evaluations.
- R6: Fast mode ends after (1 << `hold_sel`) consecutive evaluations with |error| <= 64. Those are 1, 2, 4 or 8 evaluations. The evaluation that ends fast mode still uses the fast factor.
- R7: With `avg4_en`=1 the error is evaluated only on every fourth completed window, from floor(sum of the four line levels / 4). The other windows leave the correction unchanged.
- R8: The correction changes only in the clock after cycle 12 of a valid window, and it holds its value at all other times.
- R9: The correction saturates at +32767 and -32768 (CORR_W=16) and never wraps.
- R10: A synchronous reset clears the correction to 0, selects normal gain and clears the line and hold counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| ob_in | input | 1 | Optical-black pulse |
| ob_inv | input | 1 | 1 selects an active-low OB pulse |
| pix | input | PIX_W | Unsigned converter sample |
| clamp_code | input | CLAMP_W | Target code, target = 2*code+14 |
| fast_sel | input | 2 | Fast-mode factor select |
| hold_sel | input | 2 | Quiet evaluations before fast mode ends |
| avg4_en | input | 1 | Four-line averaging enable |
| gain_chg | input | 1 | Gain-changed strobe |
| corr | output | CORR_W | Signed correction word |

## Verification
The hardest state to reach from the ports is the exit from fast mode. It needs a run of evaluations whose error magnitude straddles the 64 LSB threshold, and in some runs this happens while the accumulator sits against a saturation limit. The stimulus holds the line level constant across each window and chooses targets that give errors just above and just below the threshold. It repeats lines until the factor-32 steps drive the accumulator into the positive limit. A single line with a large error of the opposite sign then has to land exactly on the negative limit.

// File: rtl/blc_pkg.sv
package blc_pkg;
  // target level from the clamp code
  function automatic int clamp_target(input int code);
    return 2 * code + 14;
  endfunction

  // left shift applied in fast mode: 2..5 gives factor 4..32
  function automatic int fast_shift(input logic [1:0] sel);
    return int'(sel) + 2;
  endfunction

  // quiet evaluations needed before leaving fast mode
  function automatic int hold_lines(input logic [1:0] sel);
    return 1 << sel;
  endfunction
endpackage

// File: rtl/blc_window.sv
module blc_window #(
  parameter int PIX_W     = 12,
  parameter int WIN_START = 5,
  parameter int WIN_LEN   = 8,
  parameter int MIN_ACT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ob_act,
  input  logic [PIX_W-1:0] pix,
  output logic             line_done,
  output logic [PIX_W-1:0] line_avg
);
  localparam int WIN_END = WIN_START + WIN_LEN - 1;
  localparam int CNT_W   = $clog2(WIN_END + 1);
  localparam int SH      = $clog2(WIN_LEN);
  localparam int SUM_W   = PIX_W + SH;

  logic             ob_d, run;
  logic [CNT_W-1:0] cnt;
  logic [SUM_W-1:0] sum, sum_nxt;
  logic             edge_w, in_win, short_w;

  assign edge_w  = ob_act & ~ob_d & ~run;
  assign in_win  = run && cnt >= CNT_W'(WIN_START) && cnt <= CNT_W'(WIN_END);
  assign short_w = run && cnt == CNT_W'(MIN_ACT) && !ob_act;
  assign sum_nxt = sum + SUM_W'(pix);

  always_ff @(posedge clk) begin
    if (rst) begin
      ob_d <= 1'b0; run <= 1'b0; cnt <= '0; sum <= '0;
      line_done <= 1'b0; line_avg <= '0;
    end else begin
      ob_d      <= ob_act;
      line_done <= 1'b0;
      if (edge_w) begin
        run <= 1'b1; cnt <= CNT_W'(1); sum <= '0;
      end else if (short_w) begin
        run <= 1'b0; cnt <= '0;
      end else if (run) begin
        cnt <= cnt + CNT_W'(1);
        if (in_win) sum <= sum_nxt;
        if (cnt == CNT_W'(WIN_END)) begin
          run       <= 1'b0;
          line_done <= 1'b1;
          line_avg  <= PIX_W'(sum_nxt >> SH);
        end
      end
    end
  end

  // R1: a completed window yields exactly one single-clock strobe
  assert_one_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    line_done |=> !line_done);
  // R2: a pulse dropped before cycle 2 ends the window
  assert_short_abort_R2: assert property (@(posedge clk) disable iff (rst)
    short_w |=> !line_done && !run);
endmodule

// File: rtl/blc_lineavg.sv
module blc_lineavg #(
  parameter int PIX_W = 12,
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             line_done,
  input  logic [PIX_W-1:0] line_avg,
  output logic             eval,
  output logic [PIX_W-1:0] level
);
  localparam int LC_W  = $clog2(LINES);
  localparam int ACC_W = PIX_W + LC_W;
  localparam logic [LC_W-1:0] LAST = LC_W'(LINES - 1);

  logic [LC_W-1:0]  lcnt;
  logic [ACC_W-1:0] acc, acc_nxt;

  assign acc_nxt = acc + ACC_W'(line_avg);
  assign eval    = line_done && (!en || lcnt == LAST);
  assign level   = en ? PIX_W'(acc_nxt >> LC_W) : line_avg;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lcnt <= '0; acc <= '0;
    end else if (line_done) begin
      if (lcnt == LAST) begin
        lcnt <= '0; acc <= '0;
      end else begin
        lcnt <= lcnt + LC_W'(1); acc <= acc_nxt;
      end
    end
  end

  // R7: in averaging mode the first window of a group never evaluates
  assert_group_start_R7: assert property (@(posedge clk) disable iff (rst)
    (en && line_done && lcnt == '0) |-> !eval);
endmodule

// File: rtl/blc_speed.sv
module blc_speed #(
  parameter int ERR_W = 14,
  parameter int THR   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gain_chg,
  input  logic             eval,
  input  logic [ERR_W-1:0] err_mag,
  input  logic [1:0]       hold_sel,
  output logic             fast
);
  localparam int HOLD_W = 4;

  logic [HOLD_W-1:0] hold_cnt, hold_inc;
  logic              quiet;

  assign quiet    = err_mag <= ERR_W'(THR);
  assign hold_inc = hold_cnt + HOLD_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fast <= 1'b0; hold_cnt <= '0;
    end else if (gain_chg) begin
      fast <= 1'b1; hold_cnt <= '0;
    end else if (fast && eval) begin
      if (!quiet) hold_cnt <= '0;
      else if (hold_inc >= HOLD_W'(blc_pkg::hold_lines(hold_sel))) begin
        fast <= 1'b0; hold_cnt <= '0;
      end else hold_cnt <= hold_inc;
    end
  end

  assert_gain_enters_fast_R4: assert property (@(posedge clk) disable iff (rst)
    gain_chg |=> fast);
  assert_big_err_keeps_fast_R5: assert property (@(posedge clk) disable iff (rst)
    (fast && eval && err_mag > ERR_W'(THR)) |=> fast);
  assert_exit_needs_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(fast) |-> ($past(eval) && $past(err_mag) <= ERR_W'(THR)));
endmodule

// File: rtl/black_clamp_loop.sv
module black_clamp_loop #(
  parameter int PIX_W   = 12,
  parameter int CLAMP_W = 5,
  parameter int CORR_W  = 16,
  parameter int THR     = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ob_in,
  input  logic               ob_inv,
  input  logic [PIX_W-1:0]   pix,
  input  logic [CLAMP_W-1:0] clamp_code,
  input  logic [1:0]         fast_sel,
  input  logic [1:0]         hold_sel,
  input  logic               avg4_en,
  input  logic               gain_chg,
  output logic [CORR_W-1:0]  corr
);
  localparam int ERR_W  = PIX_W + 2;
  localparam int STEP_W = ERR_W + 5;
  localparam int WIDE   = (CORR_W > STEP_W ? CORR_W : STEP_W) + 1;
  localparam logic signed [WIDE-1:0] MAXV = {{(WIDE-CORR_W+1){1'b0}}, {(CORR_W-1){1'b1}}};
  localparam logic signed [WIDE-1:0] MINV = ~MAXV;

  logic                     ob_act, line_done, upd, fast;
  logic [PIX_W-1:0]         line_avg, level;
  logic signed [ERR_W-1:0]  tgt_s, lvl_s, err;
  logic [ERR_W-1:0]         err_mag;
  logic signed [STEP_W-1:0] err_ext, step;
  logic signed [WIDE-1:0]   sum_w;
  logic signed [CORR_W-1:0] corr_r;

  assign ob_act = ob_in ^ ob_inv;

  blc_window #(.PIX_W(PIX_W)) u_win (
    .clk(clk), .rst(rst), .ob_act(ob_act), .pix(pix),
    .line_done(line_done), .line_avg(line_avg));

  blc_lineavg #(.PIX_W(PIX_W)) u_avg (
    .clk(clk), .rst(rst), .en(avg4_en), .line_done(line_done),
    .line_avg(line_avg), .eval(upd), .level(level));

  assign tgt_s   = ERR_W'(blc_pkg::clamp_target(int'(clamp_code)));
  assign lvl_s   = $signed({2'b00, level});
  assign err     = tgt_s - lvl_s;
  assign err_mag = err[ERR_W-1] ? ERR_W'(-err) : ERR_W'(err);
  assign err_ext = STEP_W'(err);
  assign step    = fast ? (err_ext <<< blc_pkg::fast_shift(fast_sel)) : err_ext;
  assign sum_w   = WIDE'(corr_r) + WIDE'(step);

  blc_speed #(.ERR_W(ERR_W), .THR(THR)) u_spd (
    .clk(clk), .rst(rst), .gain_chg(gain_chg), .eval(upd),
    .err_mag(err_mag), .hold_sel(hold_sel), .fast(fast));

  always_ff @(posedge clk) begin
    if (rst) corr_r <= '0;
    else if (upd) begin
      if (sum_w > MAXV)      corr_r <= CORR_W'(MAXV);
      else if (sum_w < MINV) corr_r <= CORR_W'(MINV);
      else                   corr_r <= CORR_W'(sum_w);
    end
  end

  assign corr = corr_r;

  assert_corr_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(corr));
  assert_no_wrap_up_R9: assert property (@(posedge clk) disable iff (rst)
    (upd && !step[STEP_W-1]) |=> $signed(corr) >= $signed($past(corr)));
  assert_no_wrap_down_R9: assert property (@(posedge clk) disable iff (rst)
    (upd && step[STEP_W-1]) |=> $signed(corr) <= $signed($past(corr)));
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (corr == '0 && !fast));
endmodule

// File: tb/test_black_clamp_loop.sv
module test_black_clamp_loop;
  logic clk = 1'b0, rst = 1'b1, ob_in = 1'b0, ob_inv = 1'b0;
  logic [11:0] pix = '0;
  logic [4:0]  clamp_code = 5'd9;
  logic [1:0]  fast_sel = '0, hold_sel = '0;
  logic        avg4_en = 1'b0, gain_chg = 1'b0;
  logic signed [15:0] corr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_acc, m_hold, m_l4, m_s4;
  bit m_fast;

  typedef struct packed { int clamp; int base; int stp; int exp; } vec_t;
  localparam vec_t VECS [7] = '{
    '{9, 40, 0, -8}, '{0, 0, 0, 14}, '{31, 100, 0, -24}, '{20, 54, 0, 0},
    '{9, 29, 1, 0}, '{9, 4000, 0, -3968}, '{31, 0, 1, 73}};

  black_clamp_loop i_black_clamp_loop (
    .clk(clk), .rst(rst), .ob_in(ob_in), .ob_inv(ob_inv), .pix(pix),
    .clamp_code(clamp_code), .fast_sel(fast_sel), .hold_sel(hold_sel),
    .avg4_en(avg4_en), .gain_chg(gain_chg), .corr(corr));

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    return v > 32767 ? 32767 : (v < -32768 ? -32768 : v);
  endfunction

  task automatic model_line(input int avg);
    int lvl, err, mult, mag;
    if (avg4_en) begin
      m_s4 += avg; m_l4++;
      if (m_l4 < 4) return;
      lvl = m_s4 / 4; m_s4 = 0; m_l4 = 0;
    end else lvl = avg;
    err  = 2 * int'(clamp_code) + 14 - lvl;
    mult = m_fast ? (4 << fast_sel) : 1;
    m_acc = sat16(m_acc + err * mult);
    mag = err < 0 ? -err : err;
    if (m_fast) begin
      if (mag > 64) m_hold = 0;
      else begin
        m_hold++;
        if (m_hold >= (1 << hold_sel)) begin m_fast = 0; m_hold = 0; end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ob_in = ob_inv; gain_chg = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_acc = 0; m_fast = 0; m_hold = 0; m_l4 = 0; m_s4 = 0;
  endtask

  task automatic pulse_gain();
    @(negedge clk); gain_chg = 1'b1;
    @(negedge clk); gain_chg = 1'b0;
    m_fast = 1; m_hold = 0;
  endtask

  // one OB line; window samples are base+i*stp, everything else is full scale
  task automatic run_line(input int base, input int stp, input int plen);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      ob_in = (k < plen) ^ ob_inv;
      pix = (k >= 5 && k <= 12) ? 12'(base + (k - 5) * stp) : 12'hFFF;
      if (k == 12) check("R8 hold before update", int'(corr), m_acc);
    end
    @(negedge clk);
    if (plen >= 3) model_line((8 * base + 28 * stp) / 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R10 reset value", int'(corr), 0);

    // R3 / R1: table walk, fresh loop per vector
    for (int i = 0; i < 7; i++) begin
      clamp_code = 5'(VECS[i].clamp);
      do_reset();
      run_line(VECS[i].base, VECS[i].stp, 4);
      check("R3 R1 vector", int'(corr), VECS[i].exp);
      check("R3 model agrees", m_acc, VECS[i].exp);
    end

    // R2: two-clock pulse ignored, three-clock pulse taken
    clamp_code = 5'd9; do_reset();
    run_line(40, 0, 2);
    check("R2 short pulse ignored", int'(corr), 0);
    run_line(40, 0, 3);
    check("R2 three-clock pulse", int'(corr), -8);

    // R2: inverted polarity
    ob_inv = 1'b1; do_reset();
    run_line(20, 0, 4);
    check("R2 inverted pulse", int'(corr), 12);
    ob_inv = 1'b0; do_reset();

    // R4 R6: factor 4, leave after one quiet line
    fast_sel = 2'd0; hold_sel = 2'd0; clamp_code = 5'd9;
    pulse_gain();
    run_line(40, 0, 4);
    check("R4 fast factor 4", int'(corr), -32);
    run_line(40, 0, 4);
    check("R6 normal after 1 line", int'(corr), -40);

    // R5 R6: factor 32, two quiet lines needed
    do_reset(); fast_sel = 2'd3; hold_sel = 2'd1; clamp_code = 5'd31;
    pulse_gain();
    run_line(0, 0, 4);  check("R4 factor 32", int'(corr), 2432);
    run_line(0, 0, 4);  check("R5 big error stays fast", int'(corr), 4864);
    run_line(20, 0, 4); check("R6 first quiet line", int'(corr), 6656);
    run_line(20, 0, 4); check("R6 second quiet line", int'(corr), 8448);
    run_line(20, 0, 4); check("R6 back to normal", int'(corr), 8504);
    check("R6 model trace", m_acc, 8504);

    // R9: saturate high, then low
    do_reset(); pulse_gain();
    for (int j = 0; j < 15; j++) run_line(0, 0, 4);
    check("R9 positive limit", int'(corr), 32767);
    clamp_code = 5'd0;
    run_line(4095, 0, 4);
    check("R9 negative limit", int'(corr), -32768);

    // R10: reset from fast, saturated state
    do_reset(); clamp_code = 5'd9;
    check("R10 reset clears", int'(corr), 0);
    run_line(40, 0, 4);
    check("R10 normal gain after reset", int'(corr), -8);

    // R7: four-line averaging
    avg4_en = 1'b1; do_reset();
    run_line(40, 0, 4); check("R7 line 1 no change", int'(corr), 0);
    run_line(44, 0, 4); check("R7 line 2 no change", int'(corr), 0);
    run_line(48, 0, 4); check("R7 line 3 no change", int'(corr), 0);
    run_line(52, 0, 4); check("R7 group result", int'(corr), -14);
    avg4_en = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule